// File: doc/BRIEF.md
# Short Relative Jump and Two-Byte No-Op Program Counter Unit

This block works out the next program counter for two instructions that are each two bytes long. The first is a short relative jump. Its 11-bit signed displacement is split across two bytes: the top three bits sit in the low bits of the opcode byte, and the second byte carries the low eight bits. The second instruction is a two-byte no-op. Its second byte is discarded, and execution moves on to the following instruction. Every other opcode is reported as not handled, so the surrounding core can pass it to another unit.

The caller presents the current PC, both instruction bytes and the addressing-mode select, and pulses `dec_valid`. One clock later the unit registers its result and raises `res_valid` for one cycle. The jump target is taken relative to the end of the instruction, which is the current PC plus two. In 64-Kbyte mode the result wraps inside 16 bits. In 1-Mbyte mode it wraps inside 20 bits and may cross a 64-Kbyte page. Neither instruction touches any status flag, so the unit has no flag outputs.

Top module: `sjmp_pc_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it drops, `res_valid`, `next_pc`, `jump_taken` and `not_handled` all read zero.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `dec_valid` was high, and low in every other cycle.
- R3: An opcode byte whose top five bits are `00100` is a short jump. The result shows `jump_taken`=1 and `not_handled`=0. The displacement is the 11-bit two's-complement value {opcode[2:0], second byte}.
- R4: The target of a short jump is current PC + 2 + displacement. This holds across the whole displacement range, from -1024 (opcode low bits `100`, second byte 0x00) to +1023 (opcode low bits `011`, second byte 0xFF).
- R5: When `wide_mode`=0 (64-Kbyte mode), the result of a jump or no-op is taken modulo 2^16, and `next_pc[23:16]` is zero. This holds even when the current PC has bits set above bit 15.
- R6: When `wide_mode`=1 (1-Mbyte mode), the result of a jump or no-op is taken modulo 2^20, and `next_pc[23:20]` is zero. A target in a different 64-Kbyte page than the current PC is produced without restriction.
- R7: Opcode byte 0x00 is the two-byte no-op. It gives `next_pc` = current PC + 2, masked as in R5/R6, with `jump_taken`=0 and `not_handled`=0. Its second byte has no effect on any output.
- R8: Any other opcode byte gives `not_handled`=1, `jump_taken`=0, and `next_pc` equal to the current PC input, unchanged.
- R9: In cycles following a cycle with `dec_valid` low, `next_pc`, `jump_taken` and `not_handled` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Instruction bytes and PC are presented this cycle |
| cur_pc | input | 24 | Address of the first byte of the instruction |
| op_byte | input | 8 | First instruction byte (opcode) |
| arg_byte | input | 8 | Second instruction byte |
| wide_mode | input | 1 | 1 = 1-Mbyte addressing (20-bit wrap), 0 = 64-Kbyte addressing (16-bit wrap) |
| res_valid | output | 1 | Result registers were loaded on the last edge |
| next_pc | output | 24 | Program counter that follows the instruction |
| jump_taken | output | 1 | The instruction was a short jump |
| not_handled | output | 1 | The opcode is neither a short jump nor the two-byte no-op |

## Verification
Every result is due on the first rising edge after the edge that samples `dec_valid`. The bench drives inputs on falling edges and reads all outputs on the next falling edge. At that point exactly one rising edge has passed, and that is when `res_valid` and the result must appear. The hold checks drop `dec_valid`, change the other inputs, and let several edges pass before reading. This confirms that nothing is loaded while no request is present.

// File: rtl/sjmp_pkg.sv
package sjmp_pkg;

    // Displacement width is fixed by the two-byte encoding
    localparam int DISP_W      = 11;
    localparam int DISP_HI_W   = 3;
    localparam int INSTR_BYTES = 2;

    localparam logic [7:0] SKIP_OPCODE = 8'h00;
    localparam logic [4:0] JUMP_PREFIX = 5'b00100;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'd0,
        KIND_SKIP  = 2'd1,
        KIND_JUMP  = 2'd2
    } instr_kind_e;

    typedef struct packed {
        instr_kind_e             kind;
        logic [DISP_W-1:0]       disp;
    } decoded_t;

    function automatic logic opcode_is_jump(input logic [7:0] op);
        return op[7:DISP_HI_W] == JUMP_PREFIX;
    endfunction

    function automatic logic opcode_is_skip(input logic [7:0] op);
        return op == SKIP_OPCODE;
    endfunction

    function automatic logic [DISP_W-1:0] join_disp(input logic [7:0] op,
                                                    input logic [7:0] arg);
        return {op[DISP_HI_W-1:0], arg};
    endfunction

endpackage

// File: rtl/sjmp_decode.sv
module sjmp_decode
    import sjmp_pkg::*;
(
    input  logic [7:0] op_byte,
    input  logic [7:0] arg_byte,
    output decoded_t   dec
);

    always_comb begin
        dec.disp = join_disp(op_byte, arg_byte);
        if (opcode_is_jump(op_byte))
            dec.kind = KIND_JUMP;
        else if (opcode_is_skip(op_byte))
            dec.kind = KIND_SKIP;
        else
            dec.kind = KIND_OTHER;
    end

endmodule

// File: rtl/sjmp_target.sv
module sjmp_target
    import sjmp_pkg::*;
#(
    parameter int PC_W     = 24,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 20
) (
    input  logic [PC_W-1:0] cur_pc,
    input  logic            wide_mode,
    input  decoded_t        dec,
    output logic [PC_W-1:0] new_pc
);

    localparam int EXT_W = PC_W - DISP_W;
    localparam logic [PC_W-1:0] NARROW_MASK = {{(PC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [PC_W-1:0] WIDE_MASK   = {{(PC_W-WIDE_W){1'b0}}, {WIDE_W{1'b1}}};

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] jump_sum;
    logic [PC_W-1:0] addr_mask;

    always_comb begin
        seq_pc    = cur_pc + PC_W'(INSTR_BYTES);
        disp_ext  = {{EXT_W{dec.disp[DISP_W-1]}}, dec.disp};
        jump_sum  = seq_pc + disp_ext;
        addr_mask = wide_mode ? WIDE_MASK : NARROW_MASK;
        unique case (dec.kind)
            KIND_JUMP: new_pc = jump_sum & addr_mask;
            KIND_SKIP: new_pc = seq_pc & addr_mask;
            default:   new_pc = cur_pc;
        endcase
    end

endmodule

// File: rtl/sjmp_pc_unit.sv
module sjmp_pc_unit
    import sjmp_pkg::*;
#(
    parameter int PC_W     = 24,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_valid,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [7:0]      op_byte,
    input  logic [7:0]      arg_byte,
    input  logic            wide_mode,
    output logic            res_valid,
    output logic [PC_W-1:0] next_pc,
    output logic            jump_taken,
    output logic            not_handled
);

    decoded_t        dec;
    logic [PC_W-1:0] new_pc;

    sjmp_decode u_decode (
        .op_byte  (op_byte),
        .arg_byte (arg_byte),
        .dec      (dec)
    );

    sjmp_target #(
        .PC_W     (PC_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_target (
        .cur_pc    (cur_pc),
        .wide_mode (wide_mode),
        .dec       (dec),
        .new_pc    (new_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            next_pc     <= '0;
            jump_taken  <= 1'b0;
            not_handled <= 1'b0;
        end else begin
            res_valid <= dec_valid;
            if (dec_valid) begin
                next_pc     <= new_pc;
                jump_taken  <= (dec.kind == KIND_JUMP);
                not_handled <= (dec.kind == KIND_OTHER);
            end
        end
    end

    // R2: one-cycle result strobe
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> !res_valid);

    // R3: jump opcode classified as taken
    a_r3_jump_flags: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && op_byte[7:3] == 5'b00100) |=> (jump_taken && !not_handled));

    // R5: 64-Kbyte mode keeps the upper byte clear
    a_r5_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !wide_mode && (op_byte[7:3] == 5'b00100 || op_byte == 8'h00))
        |=> (next_pc[PC_W-1:NARROW_W] == '0));

    // R6: 1-Mbyte mode keeps bits above the 20-bit space clear
    a_r6_wide_upper: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && wide_mode && (op_byte[7:3] == 5'b00100 || op_byte == 8'h00))
        |=> (next_pc[PC_W-1:WIDE_W] == '0));

    // R7: no-op is neither taken nor rejected
    a_r7_skip_flags: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && op_byte == 8'h00) |=> (!jump_taken && !not_handled));

    // R8: rejected opcode leaves the PC as presented
    a_r8_other_pc: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && op_byte != 8'h00 && op_byte[7:3] != 5'b00100)
        |=> (not_handled && !jump_taken && next_pc == $past(cur_pc)));

    // R9: results hold while no request is present
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> ($stable(next_pc) && $stable(jump_taken) && $stable(not_handled)));

endmodule

// File: tb/sjmp_pc_unit_test.sv
module sjmp_pc_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid;
    logic [23:0] cur_pc;
    logic [7:0]  op_byte;
    logic [7:0]  arg_byte;
    logic        wide_mode;
    logic        res_valid;
    logic [23:0] next_pc;
    logic        jump_taken;
    logic        not_handled;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;   // 125 MHz

    sjmp_pc_unit uut (
        .clk         (clk),
        .rst         (rst),
        .dec_valid   (dec_valid),
        .cur_pc      (cur_pc),
        .op_byte     (op_byte),
        .arg_byte    (arg_byte),
        .wide_mode   (wide_mode),
        .res_valid   (res_valid),
        .next_pc     (next_pc),
        .jump_taken  (jump_taken),
        .not_handled (not_handled)
    );

    task automatic check(input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %06h expected %06h", req, what, act, exp);
        end
    endtask

    // Expected next PC built from R3..R8
    function automatic logic [23:0] model_pc(input logic [23:0] pc, input logic [7:0] op,
                                             input logic [7:0] arg, input logic wide);
        logic [10:0] d;
        logic [23:0] m;
        logic [23:0] s;
        m = wide ? 24'h0F_FFFF : 24'h00_FFFF;
        d = {op[2:0], arg};
        if (op[7:3] == 5'b00100) begin
            s = pc + 24'd2 + {{13{d[10]}}, d};
            return s & m;
        end else if (op == 8'h00) begin
            return (pc + 24'd2) & m;
        end
        return pc;
    endfunction

    // Present one request on a falling edge; results read one edge later
    task automatic apply(input logic [23:0] pc, input logic [7:0] op,
                         input logic [7:0] arg, input logic wide);
        cur_pc    = pc;
        op_byte   = op;
        arg_byte  = arg;
        wide_mode = wide;
        dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic run_jump(input string req, input logic [23:0] pc, input logic [7:0] op,
                            input logic [7:0] arg, input logic wide, input logic [23:0] exp);
        apply(pc, op, arg, wide);
        check("R2", "res_valid", {23'd0, res_valid}, 24'd1);
        check(req, "jump next_pc", next_pc, exp);
        check("R3", "jump_taken", {23'd0, jump_taken}, 24'd1);
        check("R3", "not_handled", {23'd0, not_handled}, 24'd0);
    endtask

    task automatic test_reset;
        rst = 1'b1; dec_valid = 1'b1; cur_pc = 24'h123456;
        op_byte = 8'h21; arg_byte = 8'h00; wide_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "res_valid in reset", {23'd0, res_valid}, 24'd0);
        check("R1", "next_pc in reset", next_pc, 24'd0);
        dec_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", "res_valid after reset", {23'd0, res_valid}, 24'd0);
        check("R1", "flags after reset", {22'd0, jump_taken, not_handled}, 24'd0);
        check("R1", "next_pc after reset", next_pc, 24'd0);
    endtask

    task automatic test_jump_range;
        run_jump("R4", 24'h001000, 8'h20, 8'h10, 1'b0, 24'h001012);
        run_jump("R4", 24'h002000, 8'h23, 8'hFF, 1'b0, 24'h002401); // +1023
        run_jump("R4", 24'h002000, 8'h24, 8'h00, 1'b0, 24'h001C02); // -1024
        run_jump("R4", 24'h000100, 8'h27, 8'hFF, 1'b0, 24'h000101); // -1
        run_jump("R4", 24'h000100, 8'h27, 8'hFE, 1'b0, 24'h000100); // -2, self
        // sweep displacement across its range in 1-Mbyte mode
        for (int k = 0; k < 2048; k += 97) begin
            logic [10:0] dd;
            dd = k[10:0];
            run_jump("R4", 24'h045678, {5'b00100, dd[10:8]}, dd[7:0], 1'b1,
                     model_pc(24'h045678, {5'b00100, dd[10:8]}, dd[7:0], 1'b1));
        end
    endtask

    task automatic test_narrow_wrap;
        run_jump("R5", 24'h00FFF0, 8'h20, 8'h20, 1'b0, 24'h000012);
        run_jump("R5", 24'h000010, 8'h24, 8'h00, 1'b0, 24'h00FC12);
        run_jump("R5", 24'h03FFF0, 8'h20, 8'h20, 1'b0, 24'h000012);
    endtask

    task automatic test_wide_wrap;
        run_jump("R6", 24'h00FFF0, 8'h20, 8'h20, 1'b1, 24'h010012); // page crossing
        run_jump("R6", 24'h0FFFF0, 8'h20, 8'h20, 1'b1, 24'h000012);
        run_jump("R6", 24'h000010, 8'h24, 8'h00, 1'b1, 24'h0FFC12);
        run_jump("R6", 24'h010005, 8'h27, 8'hF0, 1'b1, 24'h00FFF7);
    endtask

    task automatic test_skip;
        logic [23:0] first;
        apply(24'h00FFFF, 8'h00, 8'hAB, 1'b0);
        check("R7", "skip narrow next_pc", next_pc, 24'h000001);
        check("R7", "skip flags", {22'd0, jump_taken, not_handled}, 24'd0);
        apply(24'h012345, 8'h00, 8'h5A, 1'b1);
        check("R7", "skip wide next_pc", next_pc, 24'h012347);
        first = next_pc;
        apply(24'h012345, 8'h00, 8'hFF, 1'b1);
        check("R7", "skip arg ignored", next_pc, first);
        check("R7", "skip arg ignored flags", {22'd0, jump_taken, not_handled}, 24'd0);
        apply(24'h0FFFFF, 8'h00, 8'h24, 1'b1);
        check("R7", "skip wide wrap", next_pc, 24'h000001);
    endtask

    task automatic test_other;
        logic [7:0] ops [5] = '{8'h28, 8'h1F, 8'h01, 8'hFF, 8'h0C};
        foreach (ops[i]) begin
            apply(24'h9ABCDE, ops[i], 8'h33, i[0]);
            check("R8", "other next_pc", next_pc, 24'h9ABCDE);
            check("R8", "other not_handled", {23'd0, not_handled}, 24'd1);
            check("R8", "other jump_taken", {23'd0, jump_taken}, 24'd0);
        end
    endtask

    task automatic test_hold;
        apply(24'h001000, 8'h21, 8'h00, 1'b0); // -> 0x001102
        check("R4", "pre-hold next_pc", next_pc, 24'h001102);
        cur_pc = 24'h777777; op_byte = 8'h55; arg_byte = 8'h11; wide_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "res_valid idle", {23'd0, res_valid}, 24'd0);
        check("R9", "next_pc held", next_pc, 24'h001102);
        check("R9", "flags held", {22'd0, jump_taken, not_handled}, 24'd2);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_jump_range();
        test_narrow_wrap();
        test_wide_wrap();
        test_skip();
        test_other();
        test_hold();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule